// File: doc/BRIEF.md
# Decimating Resampler Phase Controller

This block produces the timing controls of a polynomial decimating resampler. It sits in the input-sample clock domain. One modulo-2^ACC_W phase accumulator advances once per valid input sample by a programmable increment, the output-to-input rate ratio written as an unsigned fraction of 2^ACC_W. A carry out of the accumulator marks an input cycle on which one output sample is due. That cycle yields a single-cycle strobe, which drives the filter enable and the write enable of the output FIFO. It also yields the fractional delay mu.

Mu is the accumulator residue left after the wrap, multiplied by a programmable reciprocal of the ratio. Strobe and mu come from the same register, so they cannot drift apart the way two independently quantized counters would. A fill indication from the downstream FIFO trims the increment by one LSB on every step. The trim makes up for the small rate error that quantizing the ratio leaves.

Top module: `dec_phase_ctl`

## Requirements
- R1: Synchronous reset clears the accumulator, the stored increment and the stored reciprocal to zero. After reset `str_o` is 0 and `mu_o` is 0.
- R2: The accumulator advances only in a cycle with `in_vld_i` high, to (accumulator + effective increment) mod 2^ACC_W. When `in_vld_i` is low it holds its value.
- R3: `str_o` is high for one cycle, the cycle after a valid input whose addition carried out of bit ACC_W-1. It is never high unless `in_vld_i` was high in the cycle before.
- R4: The first valid input after reset also raises `str_o` in the next cycle, with `mu_o` equal to 0.
- R5: On each strobe, `mu_o` takes floor(residue × `cfg_rcp_i` / 2^(ACC_W+RCP_FRAC−MU_W)). Here the residue is the accumulator value after the wrap, the reciprocal is unsigned with RCP_FRAC fraction bits, and mu is an MU_W-bit pure fraction. If the product is 1.0 or more, mu saturates to all ones. Between strobes `mu_o` holds its value.
- R6: With the increment set to 10/24 and the reciprocal set to 2.4, and the trim alternating, the mu values of the first six strobes are within 0.01 of 0, 0.6, 0.2, 0.8, 0.4, 0.
- R7: The effective increment is the stored increment minus 1 when `fifo_half_i` is 1 (FIFO more than half full), and plus 1 when it is 0.
- R8: The effective increment saturates to the range 1 to 2^ACC_W−1. It never wraps.
- R9: `cfg_we_i` captures `cfg_inc_i` and `cfg_rcp_i`. The new values apply from the first valid input in a later cycle, not to a valid input in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input-sample-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Valid input sample this cycle |
| fifo_half_i | input | 1 | Downstream FIFO more than half full |
| cfg_we_i | input | 1 | Write strobe for the increment and reciprocal registers |
| cfg_inc_i | input | ACC_W | Phase increment Fs_out/Fs_in × 2^ACC_W |
| cfg_rcp_i | input | RCP_W | Reciprocal Fs_in/Fs_out, RCP_FRAC fraction bits |
| str_o | output | 1 | Output-sample strobe (filter enable and FIFO write enable) |
| mu_o | output | MU_W | Fractional delay for the current strobe |

## Verification
The bench targets the following corner cases, each against an arithmetic model:
- Increments of 0 and all ones, driven with the trim pushing outward. A design that wraps instead of saturating either stops strobing or strobes on nearly every cycle.
- A reciprocal large enough to push the product past 1.0. A design that truncates there emits a tiny mu in place of a nearly full one.
- A configuration write made in the same cycle as a valid input. Applying the new increment one step early shifts every later strobe.
- Gaps in the valid signal. These expose an accumulator that keeps running, or a mu that changes without a strobe.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   localparam int unsigned DPC_ACC_W_DEF    = 24;
   localparam int unsigned DPC_MU_W_DEF     = 16;
   localparam int unsigned DPC_RCP_W_DEF    = 20;
   localparam int unsigned DPC_RCP_FRAC_DEF = 16;

   typedef enum logic {
      TRIM_UP   = 1'b0,
      TRIM_DOWN = 1'b1
   } trim_dir_e;
endpackage

// File: rtl/dpc_trim.sv
module dpc_trim
   import dpc_pkg::*;
#(
   parameter int unsigned ACC_W = DPC_ACC_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [ACC_W-1:0] inc_i,
   input  trim_dir_e        dir_i,
   output logic [ACC_W-1:0] eff_o
);
   localparam logic [ACC_W-1:0] INC_MAX = '1;
   localparam logic [ACC_W-1:0] INC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

   always_comb begin
      if (dir_i == TRIM_DOWN) begin
         eff_o = (inc_i <= INC_ONE) ? INC_ONE : inc_i - INC_ONE;
      end else begin
         eff_o = (inc_i == INC_MAX) ? INC_MAX : inc_i + INC_ONE;
      end
   end

   AST_EFF_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      eff_o != '0); // R8
endmodule

// File: rtl/dpc_phase_acc.sv
module dpc_phase_acc
   import dpc_pkg::*;
#(
   parameter int unsigned ACC_W = DPC_ACC_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             adv_i,
   input  logic [ACC_W-1:0] step_i,
   output logic             carry_o,
   output logic [ACC_W-1:0] nxt_o
);
   logic [ACC_W-1:0] acc_q;

   always_comb begin
      {carry_o, nxt_o} = {1'b0, acc_q} + {1'b0, step_i};
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         acc_q <= '0;
      end else if (adv_i) begin
         acc_q <= nxt_o;
      end
   end

   AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(acc_q)); // R2
endmodule

// File: rtl/dpc_mu_scale.sv
module dpc_mu_scale
   import dpc_pkg::*;
#(
   parameter int unsigned ACC_W    = DPC_ACC_W_DEF,
   parameter int unsigned RCP_W    = DPC_RCP_W_DEF,
   parameter int unsigned RCP_FRAC = DPC_RCP_FRAC_DEF,
   parameter int unsigned MU_W     = DPC_MU_W_DEF
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             ld_i,
   input  logic             zero_i,
   input  logic [ACC_W-1:0] res_i,
   input  logic [RCP_W-1:0] rcp_i,
   output logic [MU_W-1:0]  mu_o
);
   localparam int unsigned PROD_W    = ACC_W + RCP_W;
   localparam int unsigned PROD_FRAC = ACC_W + RCP_FRAC;

   logic [PROD_W-1:0] prod;
   logic [MU_W-1:0]   mu_raw;
   logic              over_one;
   logic [MU_W-1:0]   mu_q;

   always_comb begin
      prod     = {{RCP_W{1'b0}}, res_i} * {{ACC_W{1'b0}}, rcp_i};
      over_one = |prod[PROD_W-1:PROD_FRAC];
   end

   generate
      if (PROD_FRAC >= MU_W) begin : g_slice
         assign mu_raw = prod[PROD_FRAC-1 -: MU_W];
      end else begin : g_pad
         assign mu_raw = {prod[PROD_FRAC-1:0], {(MU_W-PROD_FRAC){1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         mu_q <= '0;
      end else if (ld_i) begin
         mu_q <= zero_i ? '0 : (over_one ? '1 : mu_raw);
      end
   end

   assign mu_o = mu_q;

   AST_MU_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !ld_i |=> $stable(mu_q)); // R5
   AST_MU_FIRST_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (ld_i && zero_i) |=> (mu_q == '0)); // R4
endmodule

// File: rtl/dec_phase_ctl.sv
module dec_phase_ctl
   import dpc_pkg::*;
#(
   parameter int unsigned ACC_W    = DPC_ACC_W_DEF,
   parameter int unsigned MU_W     = DPC_MU_W_DEF,
   parameter int unsigned RCP_W    = DPC_RCP_W_DEF,
   parameter int unsigned RCP_FRAC = DPC_RCP_FRAC_DEF
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             in_vld_i,
   input  logic             fifo_half_i,
   input  logic             cfg_we_i,
   input  logic [ACC_W-1:0] cfg_inc_i,
   input  logic [RCP_W-1:0] cfg_rcp_i,
   output logic             str_o,
   output logic [MU_W-1:0]  mu_o
);
   generate
      if (ACC_W < 2 || ACC_W > 32) begin : g_bad_acc
         $error("dec_phase_ctl: ACC_W must lie in 2..32");
      end
      if (MU_W < 1 || MU_W > ACC_W) begin : g_bad_mu
         $error("dec_phase_ctl: MU_W must lie in 1..ACC_W");
      end
      if (RCP_FRAC >= RCP_W) begin : g_bad_rcp
         $error("dec_phase_ctl: RCP_W needs at least one integer bit");
      end
   endgenerate

   logic [ACC_W-1:0] inc_q;
   logic [RCP_W-1:0] rcp_q;
   logic             first_q;
   logic             str_q;
   logic [ACC_W-1:0] eff_inc;
   logic             carry;
   logic [ACC_W-1:0] nxt;
   logic             due;
   trim_dir_e        dir;

   assign dir = fifo_half_i ? TRIM_DOWN : TRIM_UP;
   assign due = in_vld_i && (carry || first_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         inc_q   <= '0;
         rcp_q   <= '0;
         first_q <= 1'b1;
         str_q   <= 1'b0;
      end else begin
         if (cfg_we_i) begin
            inc_q <= cfg_inc_i;
            rcp_q <= cfg_rcp_i;
         end
         if (in_vld_i) begin
            first_q <= 1'b0;
         end
         str_q <= due;
      end
   end

   dpc_trim #(.ACC_W(ACC_W)) u_trim (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .inc_i (inc_q),
      .dir_i (dir),
      .eff_o (eff_inc)
   );

   dpc_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .adv_i   (in_vld_i),
      .step_i  (eff_inc),
      .carry_o (carry),
      .nxt_o   (nxt)
   );

   dpc_mu_scale #(
      .ACC_W    (ACC_W),
      .RCP_W    (RCP_W),
      .RCP_FRAC (RCP_FRAC),
      .MU_W     (MU_W)
   ) u_mu (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .ld_i   (due),
      .zero_i (first_q),
      .res_i  (nxt),
      .rcp_i  (rcp_q),
      .mu_o   (mu_o)
   );

   assign str_o = str_q;

   AST_STROBE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
      str_q |-> $past(in_vld_i)); // R3
   AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      !cfg_we_i |=> ($stable(inc_q) && $stable(rcp_q))); // R9
endmodule

// File: tb/dec_phase_ctl_bench.sv
module dec_phase_ctl_bench;
   localparam int AW = 24;
   localparam int MW = 16;
   localparam int RW = 20;
   localparam int RF = 16;
   localparam logic [AW-1:0] INC24 = 24'd6990507;
   localparam logic [RW-1:0] RCP24 = 20'd157286;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          vld = 1'b0;
   logic          half = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] inc = '0;
   logic [RW-1:0] rcp = '0;
   logic          str;
   logic [MW-1:0] mu;

   int n_chk = 0;
   int n_bad = 0;

   logic [AW-1:0] m_acc;
   logic [AW-1:0] m_inc;
   logic [RW-1:0] m_rcp;
   logic          m_first;
   logic          e_str;
   logic [MW-1:0] e_mu;

   logic [MW-1:0] got_mu [0:5];
   int            n_got;

   always #5 clk = ~clk;

   dec_phase_ctl u_dec_phase_ctl (
      .clk_i       (clk),
      .rst_i       (rst),
      .in_vld_i    (vld),
      .fifo_half_i (half),
      .cfg_we_i    (we),
      .cfg_inc_i   (inc),
      .cfg_rcp_i   (rcp),
      .str_o       (str),
      .mu_o        (mu)
   );

   function automatic logic [AW-1:0] trim(logic [AW-1:0] i, logic dn);
      if (dn) return (i <= 1) ? 24'd1 : i - 24'd1;
      return (i == 24'hFFFFFF) ? i : i + 24'd1;
   endfunction

   function automatic logic [MW-1:0] scale(logic [AW-1:0] r, logic [RW-1:0] c);
      logic [43:0] p;
      p = {20'd0, r} * {24'd0, c};
      if (p[43:40] != 4'd0) return 16'hFFFF;
      return p[39:24];
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; vld = 1'b0; we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_acc = '0; m_inc = '0; m_rcp = '0; m_first = 1'b1;
      e_str = 1'b0; e_mu = '0; n_got = 0;
      check({31'd0, str}, 32'd0, "R1 strobe after reset");
      check({16'd0, mu}, 32'd0, "R1 mu after reset");
   endtask

   // called at a negedge; drives, clocks, models, then checks at the next negedge
   task automatic step(input logic v, input logic h, input logic w,
                       input logic [AW-1:0] ci, input logic [RW-1:0] cr, input string tag);
      logic [AW:0] sum;
      vld = v; half = h; we = w; inc = ci; rcp = cr;
      @(posedge clk);
      e_str = 1'b0;
      if (v) begin
         sum = {1'b0, m_acc} + {1'b0, trim(m_inc, h)};
         if (m_first) begin
            e_str = 1'b1; e_mu = '0; m_first = 1'b0;
         end else if (sum[AW]) begin
            e_str = 1'b1; e_mu = scale(sum[AW-1:0], m_rcp);
         end
         m_acc = sum[AW-1:0];
      end
      if (w) begin
         m_inc = ci; m_rcp = cr;
      end
      @(negedge clk);
      vld = 1'b0; we = 1'b0;
      check({31'd0, str}, {31'd0, e_str}, {tag, " strobe"});
      check({16'd0, mu}, {16'd0, e_mu}, {tag, " mu"});
      if (str && n_got < 6) begin
         got_mu[n_got] = mu;
         n_got++;
      end
   endtask

   task automatic run(input logic [AW-1:0] ci, input logic [RW-1:0] cr, input int n,
                      input int gap_mod, input int trim_mode, input string tag);
      step(1'b0, 1'b0, 1'b1, ci, cr, "R9 cfg write");
      for (int k = 0; k < n; k++) begin
         logic v;
         logic h;
         v = (gap_mod == 0) ? 1'b1 : ((k % gap_mod) != 0);
         h = (trim_mode == 2) ? k[0] : trim_mode[0];
         step(v, h, 1'b0, ci, cr, tag);
      end
   endtask

   initial begin
      real ideal [0:5];
      real d;
      ideal[0] = 0.0; ideal[1] = 0.6; ideal[2] = 0.2;
      ideal[3] = 0.8; ideal[4] = 0.4; ideal[5] = 0.0;

      do_reset();
      // R6 and R4: 24:10 decimation with alternating trim
      run(INC24, RCP24, 40, 0, 2, "R3 R6 ratio 24:10");
      check(n_got, 6, "R6 strobe count");
      check({16'd0, got_mu[0]}, 32'd0, "R4 first mu zero");
      for (int k = 0; k < 6; k++) begin
         d = real'(got_mu[k]) / 65536.0 - ideal[k];
         if (k == 5 && d > 0.5) d = d - 1.0;
         n_chk++;
         if (d > 0.01 || d < -0.01) begin
            n_bad++;
            $display("FAIL R6 mu[%0d]: got %f expected %f", k, real'(got_mu[k]) / 65536.0, ideal[k]);
         end
      end

      // R9: a write in the same cycle as a valid input applies only later
      step(1'b1, 1'b0, 1'b1, 24'h800000, RCP24, "R9 write with valid");
      for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0, '0, '0, "R9 after write");

      // R2: gaps in the valid signal
      do_reset();
      run(24'h3A5C21, 20'h2345A, 60, 3, 1, "R2 gapped input");

      // R7: fixed trim direction each way
      do_reset();
      run(24'h555555, 20'h30000, 50, 0, 1, "R7 trim down");
      do_reset();
      run(24'h555555, 20'h30000, 50, 0, 0, "R7 trim up");

      // R8: saturation at both ends of the increment range
      do_reset();
      run(24'h000000, 20'h10000, 20, 0, 1, "R8 low clamp");
      run(24'h000001, 20'h10000, 10, 0, 1, "R8 one minus");
      run(24'hFFFFFF, 20'h10000, 20, 0, 0, "R8 high clamp");

      // R5: reciprocal large enough to drive the product to 1.0 or more
      do_reset();
      run(24'h400000, 20'hFFFFF, 30, 0, 2, "R5 mu saturation");
      // R5 and R3: sweep of ratios
      for (int r = 1; r < 8; r++) begin
         do_reset();
         run(AW'(r * 24'h1F3A7 + 24'h0A0000), RW'(20'h10000 + r * 20'h1777), 40, r % 4, 2, "R5 R3 sweep");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule